// File: doc/BRIEF.md
# PPP HDLC Transmit Octet Framer

This block turns a stream of packet octets into a byte-wide, HDLC-framed line stream for PPP. It handles one octet per clock. It places flag octets between frames and appends a frame check sequence after the last octet of each normal packet. The check sequence is a 16-bit or 32-bit CRC, chosen by a static select pin. Any payload or check octet that would look like a control character is escaped. A packet marked as aborted is closed with an abort sequence and gets no check sequence.

The upstream side is a valid/ready stream. `s_valid`, `s_data`, `s_last` and `s_abort` must stay stable from the cycle `s_valid` rises until the cycle in which `s_valid && s_ready` is seen at a clock edge. An octet is taken only in that cycle. `s_abort` is meaningful only on the beat that carries `s_last`. That beat's octet is sent, and then the abort sequence follows.

The downstream side is driven by a transmit-enable request. In each cycle where `tx_en` is high and `tx_valid` is high, the octet on `tx_data` is taken. When `tx_en` is low, nothing is taken and the framer holds its position. `tx_valid` is low only while a frame is in progress and the next payload octet has not yet arrived. `fcs32_sel` may change only while the line is idle.

Top module: `ppp_hdlc_tx_framer`

## Requirements
- R1: After reset, and whenever no packet is in progress, every enabled cycle sends the flag octet 0x7E with `tx_valid` high. `s_ready` stays low during these flag cycles.
- R2: The line carries exactly one flag octet between the end of one frame and the first octet of the next, when the next packet is already pending. A payload octet is never accepted in a cycle that sends 0x7E.
- R3: With `fcs32_sel` low, a normal packet is followed by a 2-octet check sequence. It is the CRC with generator x^16+x^12+x^5+1, preset 0xFFFF, processed least significant bit first, then ones-complemented and sent low octet first.
- R4: With `fcs32_sel` high, the check sequence is the 32-bit CRC with the Ethernet generator (reflected form 0xEDB88320), preset 0xFFFFFFFF. It is complemented and sent low octet first as 4 octets.
- R5: A payload octet equal to 0x7E or 0x7D is sent as 0x7D followed by the octet XOR 0x20. While the 0x7D is on the line, `s_ready` is low. The octet is accepted in the cycle that sends its second half.
- R6: Check-sequence octets equal to 0x7E or 0x7D are escaped in the same way.
- R7: When the last beat of a packet carries `s_abort`, that beat's octet is followed by 0x7D and then 0x7E, with no check sequence.
- R8: In a cycle with `tx_en` low, `s_ready` is low and no state advances. The same `tx_data` is presented again in the next cycle.
- R9: Inside a frame, if the next payload octet is not valid, `tx_valid` is low. Transmission resumes with that octet once it arrives.
- R10: Reset is active-low `rst_n`, applied at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fcs32_sel | input | 1 | 1 = 32-bit check sequence, 0 = 16-bit (static) |
| s_valid | input | 1 | Upstream octet valid |
| s_ready | output | 1 | Upstream octet accepted this cycle (with s_valid) |
| s_data | input | 8 | Upstream payload octet |
| s_last | input | 1 | Marks the final octet of a packet |
| s_abort | input | 1 | With s_last: abort this packet |
| tx_en | input | 1 | Downstream request; octet taken this cycle |
| tx_valid | output | 1 | tx_data holds a line octet |
| tx_data | output | 8 | Line octet |

## Verification
The block has no top-level parameters, so the bench builds it in its only configuration. It reaches both check-sequence widths by running the same packet table once with `fcs32_sel` low and once with it high. The downstream request is randomly gapped, which exercises stalls at every framer state. A search over single-octet payloads picks one whose 16-bit check sequence holds a control character, so escaping inside the check sequence is exercised. Directed cycle-by-cycle runs cover the abort hand-off, the single shared flag, data underrun and the stall hold.

// File: rtl/ppp_hdlc_tx_pkg.sv
package ppp_hdlc_tx_pkg;

  localparam int OCTET_W        = 8;
  localparam int FCS_MAX_OCTETS = 4;
  localparam int CRC_W          = OCTET_W * FCS_MAX_OCTETS;
  localparam int FCS_IDX_W      = $clog2(FCS_MAX_OCTETS);

  localparam logic [OCTET_W-1:0] FLAG_OCTET = 8'h7E;
  localparam logic [OCTET_W-1:0] ESC_OCTET  = 8'h7D;
  localparam logic [OCTET_W-1:0] ESC_FLIP   = 8'h20;

  localparam logic [15:0]      CRC16_REFL_POLY = 16'h8408;
  localparam logic [31:0]      CRC32_REFL_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC16_PRESET    = CRC_W'(32'h0000FFFF);
  localparam logic [CRC_W-1:0] CRC32_PRESET    = CRC_W'(32'hFFFFFFFF);

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_DATA  = 2'd1,
    FR_FCS   = 2'd2,
    FR_ABORT = 2'd3
  } fr_state_e;

  // One octet into the narrow CRC, low bit first.
  function automatic logic [15:0] crc16_octet(input logic [15:0] crc_in,
                                               input logic [OCTET_W-1:0] d);
    logic [15:0] c;
    c = crc_in;
    for (int b = 0; b < OCTET_W; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC16_REFL_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

  // One octet into the wide CRC, low bit first.
  function automatic logic [31:0] crc32_octet(input logic [31:0] crc_in,
                                               input logic [OCTET_W-1:0] d);
    logic [31:0] c;
    c = crc_in;
    for (int b = 0; b < OCTET_W; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC32_REFL_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/ppp_fcs_engine.sv
module ppp_fcs_engine
  import ppp_hdlc_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_sel,
  input  logic               preset,
  input  logic               advance,
  input  logic [OCTET_W-1:0] octet,
  output logic [CRC_W-1:0]   crc_q
);

  logic [CRC_W-1:0] crc_next;

  always_comb begin
    if (wide_sel) crc_next = crc32_octet(crc_q, octet);
    else          crc_next = {{(CRC_W-16){1'b0}}, crc16_octet(crc_q[15:0], octet)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= CRC32_PRESET;
    else if (preset)  crc_q <= wide_sel ? CRC32_PRESET : CRC16_PRESET;
    else if (advance) crc_q <= crc_next;
  end

endmodule

// File: rtl/ppp_fcs_serializer.sv
module ppp_fcs_serializer
  import ppp_hdlc_tx_pkg::*;
(
  input  logic [CRC_W-1:0]     crc,
  input  logic                 wide_sel,
  input  logic [FCS_IDX_W-1:0] idx,
  output logic [OCTET_W-1:0]   octet,
  output logic                 final_octet
);

  localparam int NARROW_OCTETS = FCS_MAX_OCTETS / 2;

  logic [CRC_W-1:0]   fcs_word;
  logic [OCTET_W-1:0] lane [FCS_MAX_OCTETS];

  assign fcs_word = ~crc;

  for (genvar g = 0; g < FCS_MAX_OCTETS; g++) begin : g_lane
    assign lane[g] = fcs_word[g*OCTET_W +: OCTET_W];
  end

  assign octet       = lane[idx];
  assign final_octet = wide_sel ? (idx == FCS_IDX_W'(FCS_MAX_OCTETS - 1))
                                : (idx == FCS_IDX_W'(NARROW_OCTETS - 1));

endmodule

// File: rtl/ppp_octet_stuffer.sv
module ppp_octet_stuffer
  import ppp_hdlc_tx_pkg::*;
(
  input  logic [OCTET_W-1:0] raw,
  input  logic               second_half,
  output logic [OCTET_W-1:0] line_octet,
  output logic               needs_escape
);

  assign needs_escape = (raw == FLAG_OCTET) || (raw == ESC_OCTET);

  always_comb begin
    if (second_half)       line_octet = raw ^ ESC_FLIP;
    else if (needs_escape) line_octet = ESC_OCTET;
    else                   line_octet = raw;
  end

endmodule

// File: rtl/ppp_hdlc_tx_framer.sv
module ppp_hdlc_tx_framer
  import ppp_hdlc_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fcs32_sel,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [OCTET_W-1:0] s_data,
  input  logic               s_last,
  input  logic               s_abort,
  input  logic               tx_en,
  output logic               tx_valid,
  output logic [OCTET_W-1:0] tx_data
);

  fr_state_e            state_q, state_d;
  logic                 esc_pend_q, esc_pend_d;
  logic [FCS_IDX_W-1:0] idx_q, idx_d;

  logic [CRC_W-1:0]     crc_q;
  logic                 crc_preset, crc_adv;
  logic [OCTET_W-1:0]   fcs_octet, raw_octet, stuffed;
  logic                 fcs_last, needs_esc;

  assign crc_preset = (state_q == FR_IDLE);
  assign raw_octet  = (state_q == FR_FCS) ? fcs_octet : s_data;

  ppp_fcs_engine u_fcs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide_sel (fcs32_sel),
    .preset   (crc_preset),
    .advance  (crc_adv),
    .octet    (s_data),
    .crc_q    (crc_q)
  );

  ppp_fcs_serializer u_ser (
    .crc         (crc_q),
    .wide_sel    (fcs32_sel),
    .idx         (idx_q),
    .octet       (fcs_octet),
    .final_octet (fcs_last)
  );

  ppp_octet_stuffer u_stuff (
    .raw          (raw_octet),
    .second_half  (esc_pend_q),
    .line_octet   (stuffed),
    .needs_escape (needs_esc)
  );

  always_comb begin
    state_d    = state_q;
    esc_pend_d = esc_pend_q;
    idx_d      = idx_q;
    s_ready    = 1'b0;
    tx_valid   = 1'b1;
    tx_data    = FLAG_OCTET;
    crc_adv    = 1'b0;
    unique case (state_q)
      FR_IDLE: begin
        esc_pend_d = 1'b0;
        if (tx_en && s_valid) state_d = FR_DATA;
      end
      FR_DATA: begin
        tx_valid = s_valid;
        tx_data  = stuffed;
        s_ready  = tx_en && (esc_pend_q || !needs_esc);
        if (tx_en && s_valid) begin
          if (needs_esc && !esc_pend_q) begin
            esc_pend_d = 1'b1;
          end else begin
            esc_pend_d = 1'b0;
            crc_adv    = !s_abort;
            if (s_last) begin
              idx_d   = '0;
              state_d = s_abort ? FR_ABORT : FR_FCS;
            end
          end
        end
      end
      FR_FCS: begin
        tx_data = stuffed;
        if (tx_en) begin
          if (needs_esc && !esc_pend_q) begin
            esc_pend_d = 1'b1;
          end else begin
            esc_pend_d = 1'b0;
            if (fcs_last) state_d = FR_IDLE;
            else          idx_d   = idx_q + FCS_IDX_W'(1);
          end
        end
      end
      FR_ABORT: begin
        tx_data = ESC_OCTET;
        if (tx_en) state_d = FR_IDLE;
      end
      default: state_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= FR_IDLE;
      esc_pend_q <= 1'b0;
      idx_q      <= '0;
    end else begin
      state_q    <= state_d;
      esc_pend_q <= esc_pend_d;
      idx_q      <= idx_d;
    end
  end

endmodule

// File: rtl/ppp_hdlc_tx_framer_chk.sv
module ppp_hdlc_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic [7:0] s_data,
  input logic       tx_en,
  input logic       tx_valid,
  input logic [7:0] tx_data
);

  // R1
  flag_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_data == 8'h7E) |-> !s_ready);

  // R2
  accept_not_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (tx_valid && tx_data != 8'h7E));

  // R5
  esc_hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_data == 8'h7D) |-> !s_ready);

  // R5
  esc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_valid && tx_data == 8'h7D) |=>
      (tx_valid && (tx_data == 8'h5E || tx_data == 8'h5D || tx_data == 8'h7E)));

  // R8
  stall_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !s_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && tx_valid && s_valid && $past(s_valid)) |=>
      (!$stable(s_data) || $stable(tx_data)));

endmodule

bind ppp_hdlc_tx_framer ppp_hdlc_tx_framer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .s_data   (s_data),
  .tx_en    (tx_en),
  .tx_valid (tx_valid),
  .tx_data  (tx_data)
);

// File: tb/ppp_hdlc_tx_framer_test.sv
module ppp_hdlc_tx_framer_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fcs32_sel;
  logic       s_valid, s_ready, s_last, s_abort;
  logic [7:0] s_data;
  logic       tx_en, tx_valid;
  logic [7:0] tx_data;

  always #4 clk = ~clk;

  ppp_hdlc_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .fcs32_sel(fcs32_sel),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_abort(s_abort),
    .tx_en(tx_en), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  int checks = 0;
  int fails  = 0;

  // {abort, last, data}
  localparam int NBEAT = 14;
  localparam logic [9:0] BEATS [NBEAT] = '{
    {2'b00, 8'h01}, {2'b00, 8'h02}, {2'b01, 8'h03},
    {2'b00, 8'h7E}, {2'b00, 8'h11}, {2'b00, 8'h7D}, {2'b01, 8'h20},
    {2'b11, 8'h7D},
    {2'b00, 8'h31}, {2'b00, 8'h32}, {2'b00, 8'h33},
    {2'b00, 8'h34}, {2'b00, 8'h35}, {2'b01, 8'h36}
  };

  logic [7:0] out_buf [512];
  logic [7:0] exp_buf [512];
  int   out_n, exp_n;
  logic rec_on  = 1'b0;
  logic en_rand = 1'b0;
  logic en_fixed = 1'b1;
  logic [7:0] lf = 8'hA5;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_out(input logic [7:0] b);
    if (!(b == 8'h7E && out_n > 0 && out_buf[out_n-1] == 8'h7E)) begin
      out_buf[out_n] = b;
      out_n++;
    end
  endtask

  task automatic push_exp(input logic [7:0] b);
    if (!(b == 8'h7E && exp_n > 0 && exp_buf[exp_n-1] == 8'h7E)) begin
      exp_buf[exp_n] = b;
      exp_n++;
    end
  endtask

  task automatic push_exp_stuffed(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin
      push_exp(8'h7D);
      push_exp(b ^ 8'h20);
    end else push_exp(b);
  endtask

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [7:0] d, input logic wide);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (wide) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      else      r = (r[0] ^ d[i]) ? (((r >> 1) ^ 32'h8408) & 32'hFFFF) : (r >> 1);
    end
    return r;
  endfunction

  task automatic tick(output logic hs);
    if (en_rand) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      tx_en = lf[0] | lf[1];
    end else tx_en = en_fixed;
    #1;
    hs = s_valid && s_ready;
    if (rec_on && tx_en && tx_valid) push_out(tx_data);
    @(negedge clk);
  endtask

  task automatic send_beat(input logic [7:0] d, input logic last, input logic ab);
    logic hs;
    s_valid = 1'b1; s_data = d; s_last = last; s_abort = ab;
    do tick(hs); while (!hs);
    s_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    logic hs;
    s_valid = 1'b0;
    for (int i = 0; i < n; i++) tick(hs);
  endtask

  task automatic compare_stream(input string tag);
    chk(out_n == exp_n, tag, out_n, exp_n);
    for (int i = 0; i < exp_n && i < out_n; i++)
      chk(out_buf[i] == exp_buf[i], tag, out_buf[i], exp_buf[i]);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] crc;
    logic [7:0]  pick;
    logic        found;
    rst_n = 1'b0; fcs32_sel = 1'b0; s_valid = 1'b0; s_data = 8'h00;
    s_last = 1'b0; s_abort = 1'b0; tx_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 / R1: reset state is idle flags
    chk(tx_valid && tx_data == 8'h7E && !s_ready, "R10", {tx_valid, tx_data, s_ready}, {1'b1, 8'h7E, 1'b0});
    @(negedge clk); #1;
    chk(tx_valid && tx_data == 8'h7E, "R1", tx_data, 8'h7E);
    @(negedge clk);

    // R5: escaped payload octet, ready low on the 0x7D cycle
    s_valid = 1'b1; s_data = 8'h7E; s_last = 1'b1; s_abort = 1'b0; tx_en = 1'b1;
    #1 chk(tx_data == 8'h7E && !s_ready, "R1", tx_data, 8'h7E);
    @(negedge clk); #1;
    chk(tx_data == 8'h7D && !s_ready, "R5", {s_ready, tx_data}, {1'b0, 8'h7D});
    @(negedge clk); #1;
    chk(tx_data == 8'h5E && s_ready, "R5", {s_ready, tx_data}, {1'b1, 8'h5E});
    @(negedge clk);
    drain(12);

    // R8: stall holds the octet
    s_valid = 1'b1; s_data = 8'h41; s_last = 1'b1; tx_en = 1'b1;
    @(negedge clk);
    tx_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1 chk(tx_valid && tx_data == 8'h41 && !s_ready, "R8", {s_ready, tx_data}, {1'b0, 8'h41});
      @(negedge clk);
    end
    tx_en = 1'b1;
    #1 chk(s_ready, "R8", s_ready, 1);
    @(negedge clk);
    drain(12);

    // R9: underrun inside a frame
    s_valid = 1'b1; s_data = 8'h42; s_last = 1'b0;
    @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    #1 chk(!tx_valid, "R9", tx_valid, 0);
    @(negedge clk);
    s_valid = 1'b1; s_data = 8'h43; s_last = 1'b1;
    #1 chk(tx_valid && tx_data == 8'h43, "R9", tx_data, 8'h43);
    @(negedge clk);
    drain(12);

    // R7 abort, then R2 single shared flag before the pending packet
    s_valid = 1'b1; s_data = 8'h55; s_last = 1'b1; s_abort = 1'b1;
    @(negedge clk); #1;
    chk(tx_data == 8'h55 && s_ready, "R7", tx_data, 8'h55);
    @(negedge clk);
    s_data = 8'h66; s_abort = 1'b0;
    #1 chk(tx_data == 8'h7D && !s_ready, "R7", tx_data, 8'h7D);
    @(negedge clk); #1;
    chk(tx_data == 8'h7E && !s_ready, "R7", tx_data, 8'h7E);
    @(negedge clk); #1;
    chk(tx_valid && tx_data == 8'h66 && s_ready, "R2", tx_data, 8'h66);
    @(negedge clk);
    drain(12);

    // Table passes: R3 (narrow) and R4 (wide), gapped tx_en
    for (int pass = 0; pass < 2; pass++) begin
      fcs32_sel = pass[0];
      drain(4);
      out_n = 0; exp_n = 0;
      crc = pass[0] ? 32'hFFFFFFFF : 32'h0000FFFF;
      push_exp(8'h7E);
      for (int i = 0; i < NBEAT; i++) begin
        push_exp_stuffed(BEATS[i][7:0]);
        if (BEATS[i][8]) begin
          if (BEATS[i][9]) begin
            push_exp(8'h7D); push_exp(8'h7E);
          end else begin
            crc = ~crc_ref(crc, BEATS[i][7:0], pass[0]);
            for (int k = 0; k < (pass[0] ? 4 : 2); k++) push_exp_stuffed(crc[8*k +: 8]);
            push_exp(8'h7E);
          end
          crc = pass[0] ? 32'hFFFFFFFF : 32'h0000FFFF;
        end else crc = crc_ref(crc, BEATS[i][7:0], pass[0]);
      end
      rec_on = 1'b1; en_rand = 1'b1;
      for (int i = 0; i < NBEAT; i++) send_beat(BEATS[i][7:0], BEATS[i][8], BEATS[i][9]);
      drain(40);
      rec_on = 1'b0; en_rand = 1'b0;
      compare_stream(pass == 0 ? "R3" : "R4");
    end

    // R6: a payload whose narrow check sequence contains a control octet
    fcs32_sel = 1'b0;
    drain(4);
    found = 1'b0; pick = 8'h00;
    for (int b = 0; b < 256; b++) begin
      crc = ~crc_ref(32'h0000FFFF, b[7:0], 1'b0);
      if (!found && (crc[7:0] == 8'h7E || crc[7:0] == 8'h7D ||
                     crc[15:8] == 8'h7E || crc[15:8] == 8'h7D)) begin
        found = 1'b1; pick = b[7:0];
      end
    end
    chk(found, "R6", found, 1);
    out_n = 0; exp_n = 0;
    crc = ~crc_ref(32'h0000FFFF, pick, 1'b0);
    push_exp(8'h7E);
    push_exp_stuffed(pick);
    push_exp_stuffed(crc[7:0]);
    push_exp_stuffed(crc[15:8]);
    push_exp(8'h7E);
    rec_on = 1'b1;
    send_beat(pick, 1'b1, 1'b0);
    drain(12);
    rec_on = 1'b0;
    compare_stream("R6");

    summary();
    $finish;
  end

endmodule